// File: doc/BRIEF.md
# Two-Level Address Translation Walker

The block sits between a device master and memory and turns 32-bit device addresses into 40-bit physical addresses. A device address carries three fields: a 10-bit directory index in bits 31:22, a 10-bit table index in bits 21:12 and a 12-bit page offset in bits 11:0. On a miss the walker fetches one directory word and then one page word from tables that software has placed in memory. Each table holds 1024 four-byte words, so it fills one 4 KiB page. A small translation cache holds recent results. A hit returns the translation one cycle after the request without any memory traffic.

Software uses a word-indexed register port to control the walker. Through it, software enables translation, sets the directory base, flushes the cache and handles faults. A walk that meets an invalid entry, or a write to a read-only page, gives the requester an error response. The same event records the device address, sets a status bit and raises the interrupt until software clears the bit.

Top module: `iova_walker`

## Requirements
- R1: After reset, the control, status and fault-address registers read 0, `irq` is low and the cache is empty, so the first translation after enabling performs two memory reads.
- R2: While control bit 0 is clear, an accepted request is answered one cycle later with `rsp_paddr` = {8'h00, vaddr}, `rsp_fault` low and no memory read.
- R3: Register index 1 holds the directory base. Its bits 11:0 read as zero. A miss first reads the directory word at {base[31:12], vaddr[31:22], 2'b00}.
- R4: A directory word is valid when its bit 0 is 1. The page word is read only after the directory data has returned, at {dir[31:6], 6'b0} + 4 × vaddr[21:12]. At most one read is outstanding, and `mem_req_valid` and `mem_req_addr` hold steady until accepted.
- R5: A page word is valid when its bit 0 is 1 and writable when its bit 2 is 1. The result is {pte[11:4], pte[31:12], vaddr[11:0]}. It is returned one cycle after the page data arrives.
- R6: A cached page answers one cycle after acceptance with no memory read. The cache holds CACHE_ENTRIES translations. A fill replaces the oldest fill first.
- R7: Writing register index 2 with bit 4 set invalidates every cached translation and restarts replacement at the first slot. A walk in flight during such a write still answers but does not fill. Bit 4 reads back the last value written.
- R8: Faults report `rsp_fault` high with `rsp_paddr` zero, latch vaddr into register index 4 and raise `irq`. The three fault kinds set these bits of register index 3: invalid directory word sets bit 0, invalid page word sets bit 1, and a write to a non-writable page sets bit 2. The write check applies to cache hits as well as walks.
- R9: Writing value W to register index 3 leaves status & W[2:0]. `irq` equals the OR of the status bits. A walk that faults fills no cache entry.
- R10: Register index 0 bit 0 is the enable bit. Register reads are combinational from `reg_addr`, and register writes take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Fault interrupt, high while any status bit is set |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Device address to translate |
| req_write | input | 1 | Request is a write access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 40 | Translated physical address |
| rsp_fault | output | 1 | Response is an error |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Table word returned |

## Verification
Responses to bypass and cache-hit requests are due on the first cycle after acceptance. With memory latency L, measured from the cycle a read is accepted to the cycle its data is driven, a full walk answers 2L+3 cycles after acceptance and a directory fault answers L+2 cycles after acceptance. The bench changes L from page to page. It drives every input on the falling edge and counts falling edges from acceptance until `rsp_valid` appears, so each latency is compared exactly against these formulas. Register effects are read back on the falling edge that follows the write's clock edge.

// File: rtl/iovw_pkg.sv
package iovw_pkg;
   localparam int VA_W  = 32;
   localparam int PA_W  = 40;
   localparam int OFF_W = 12;
   localparam int IDX_W = 10;
   localparam int VPN_W = VA_W - OFF_W;
   localparam int PPN_W = PA_W - OFF_W;
   localparam int ST_W  = 3;
   localparam int RA_W  = 3;

   localparam logic [RA_W-1:0] RA_CTRL  = 3'd0;
   localparam logic [RA_W-1:0] RA_BASE  = 3'd1;
   localparam logic [RA_W-1:0] RA_FLUSH = 3'd2;
   localparam logic [RA_W-1:0] RA_STAT  = 3'd3;
   localparam logic [RA_W-1:0] RA_FADDR = 3'd4;

   localparam int FLUSH_BIT = 4;
   localparam int ST_DIR = 0;
   localparam int ST_PTE = 1;
   localparam int ST_RO  = 2;

   typedef enum logic [2:0] {
      W_IDLE, W_DIR_REQ, W_DIR_WAIT, W_PTE_REQ, W_PTE_WAIT
   } walk_st_t;

   // page word: bits 31:12 -> pa 31:12, bits 11:4 -> pa 39:32
   function automatic logic [PPN_W-1:0] pte_ppn(input logic [31:0] e);
      return {e[11:4], e[31:12]};
   endfunction
endpackage

// File: rtl/iovw_csr.sv
module iovw_csr
   import iovw_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [RA_W-1:0]  reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   input  logic             fault_set,
   input  logic [ST_W-1:0]  fault_code,
   input  logic [VA_W-1:0]  fault_va,
   output logic             enable,
   output logic [31:0]      tbase,
   output logic             flush_pulse,
   output logic             irq
);
   logic            en_q;
   logic [31:12]    base_q;
   logic            flush_q;
   logic [ST_W-1:0] stat_q;
   logic [VA_W-1:0] faddr_q;
   logic [ST_W-1:0] stat_kept;

   wire wr_ctrl  = reg_we && (reg_addr == RA_CTRL);
   wire wr_base  = reg_we && (reg_addr == RA_BASE);
   wire wr_flush = reg_we && (reg_addr == RA_FLUSH);
   wire wr_stat  = reg_we && (reg_addr == RA_STAT);

   assign stat_kept = wr_stat ? (stat_q & reg_wdata[ST_W-1:0]) : stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         base_q  <= '0;
         flush_q <= 1'b0;
         stat_q  <= '0;
         faddr_q <= '0;
      end else begin
         if (wr_ctrl)  en_q    <= reg_wdata[0];
         if (wr_base)  base_q  <= reg_wdata[31:12];
         if (wr_flush) flush_q <= reg_wdata[FLUSH_BIT];
         stat_q <= stat_kept | (fault_set ? fault_code : '0);
         if (fault_set) faddr_q <= fault_va;
      end
   end

   assign enable      = en_q;
   assign tbase       = {base_q, 12'h000};
   assign flush_pulse = wr_flush && reg_wdata[FLUSH_BIT];
   assign irq         = |stat_q;

   always_comb begin
      case (reg_addr)
         RA_CTRL:  reg_rdata = {31'b0, en_q};
         RA_BASE:  reg_rdata = {base_q, 12'h000};
         RA_FLUSH: reg_rdata = 32'(flush_q) << FLUSH_BIT;
         RA_STAT:  reg_rdata = {{(32-ST_W){1'b0}}, stat_q};
         RA_FADDR: reg_rdata = faddr_q;
         default:  reg_rdata = '0;
      endcase
   end

   p_irq_after_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fault_set |=> irq);
   p_faddr_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fault_set |=> (reg_addr != RA_FADDR) || (reg_rdata == $past(fault_va)));
   p_clear_drops_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && reg_wdata[ST_W-1:0] == '0 && !fault_set) |=> !irq);
endmodule

// File: rtl/iovw_tlb.sv
module iovw_tlb
   import iovw_pkg::*;
#(
   parameter int ENTRIES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [VPN_W-1:0] look_vpn,
   output logic             hit,
   output logic [PPN_W-1:0] hit_ppn,
   output logic             hit_wr,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic             fill_wr
);
   localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

   logic [ENTRIES-1:0] vld;
   logic [ENTRIES-1:0] match;
   logic [ENTRIES-1:0] wrb;
   logic [PPN_W-1:0]   ppn_a [ENTRIES];
   logic [PTR_W-1:0]   ptr_q;

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
         logic             v_q;
         logic             w_q;
         logic [VPN_W-1:0] t_q;
         logic [PPN_W-1:0] p_q;
         wire take = fill_en && (ptr_q == PTR_W'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               w_q <= 1'b0;
               t_q <= '0;
               p_q <= '0;
            end else if (flush) begin
               v_q <= 1'b0;
            end else if (take) begin
               v_q <= 1'b1;
               w_q <= fill_wr;
               t_q <= fill_vpn;
               p_q <= fill_ppn;
            end
         end

         assign vld[g]   = v_q;
         assign wrb[g]   = w_q;
         assign match[g] = v_q && (t_q == look_vpn);
         assign ppn_a[g] = p_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr_q <= '0;
      else if (flush)   ptr_q <= '0;
      else if (fill_en) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
   end

   always_comb begin
      hit_ppn = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (match[i]) hit_ppn = hit_ppn | ppn_a[i];
   end

   assign hit    = |match;
   assign hit_wr = |(match & wrb);

   p_single_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));
   p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (vld == '0));
endmodule

// File: rtl/iovw_walk.sv
module iovw_walk
   import iovw_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [31:0]      tbase,
   input  logic             flush_pulse,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic             req_write,
   output logic             rsp_valid,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic             rsp_fault,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [31:0]      mem_req_addr,
   input  logic             mem_rsp_valid,
   input  logic [31:0]      mem_rsp_data,
   input  logic             hit,
   input  logic [PPN_W-1:0] hit_ppn,
   input  logic             hit_wr,
   output logic             fill_en,
   output logic [VPN_W-1:0] fill_vpn,
   output logic [PPN_W-1:0] fill_ppn,
   output logic             fill_wr,
   output logic             fault_set,
   output logic [ST_W-1:0]  fault_code,
   output logic [VA_W-1:0]  fault_va
);
   walk_st_t        st_q, st_d;
   logic [VA_W-1:0] va_q;
   logic            wr_q;
   logic            drop_q;
   logic [31:0]     pt_addr_q;
   logic            rsp_set, rsp_flt_d, fill_ok;
   logic [PA_W-1:0] rsp_pa_d;
   logic            rsp_valid_q, rsp_fault_q;
   logic [PA_W-1:0] rsp_paddr_q;

   wire unused_bits = ^{tbase[11:0], mem_rsp_data[5:1]};

   always_comb begin
      st_d       = st_q;
      fault_set  = 1'b0;
      fault_code = '0;
      rsp_set    = 1'b0;
      rsp_flt_d  = 1'b0;
      rsp_pa_d   = '0;
      fill_ok    = 1'b0;
      case (st_q)
         W_IDLE: if (req_valid) begin
            if (!enable) begin
               rsp_set  = 1'b1;
               rsp_pa_d = {{(PA_W-VA_W){1'b0}}, req_vaddr};
            end else if (hit) begin
               rsp_set = 1'b1;
               if (req_write && !hit_wr) begin
                  rsp_flt_d         = 1'b1;
                  fault_set         = 1'b1;
                  fault_code[ST_RO] = 1'b1;
               end else begin
                  rsp_pa_d = {hit_ppn, req_vaddr[OFF_W-1:0]};
               end
            end else begin
               st_d = W_DIR_REQ;
            end
         end
         W_DIR_REQ: if (mem_req_ready) st_d = W_DIR_WAIT;
         W_DIR_WAIT: if (mem_rsp_valid) begin
            if (!mem_rsp_data[0]) begin
               st_d               = W_IDLE;
               rsp_set            = 1'b1;
               rsp_flt_d          = 1'b1;
               fault_set          = 1'b1;
               fault_code[ST_DIR] = 1'b1;
            end else begin
               st_d = W_PTE_REQ;
            end
         end
         W_PTE_REQ: if (mem_req_ready) st_d = W_PTE_WAIT;
         W_PTE_WAIT: if (mem_rsp_valid) begin
            st_d    = W_IDLE;
            rsp_set = 1'b1;
            if (!mem_rsp_data[0]) begin
               rsp_flt_d          = 1'b1;
               fault_set          = 1'b1;
               fault_code[ST_PTE] = 1'b1;
            end else if (wr_q && !mem_rsp_data[2]) begin
               rsp_flt_d         = 1'b1;
               fault_set         = 1'b1;
               fault_code[ST_RO] = 1'b1;
            end else begin
               rsp_pa_d = {pte_ppn(mem_rsp_data), va_q[OFF_W-1:0]};
               fill_ok  = 1'b1;
            end
         end
         default: st_d = W_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= W_IDLE;
         va_q        <= '0;
         wr_q        <= 1'b0;
         drop_q      <= 1'b0;
         pt_addr_q   <= '0;
         rsp_valid_q <= 1'b0;
         rsp_fault_q <= 1'b0;
         rsp_paddr_q <= '0;
      end else begin
         st_q        <= st_d;
         rsp_valid_q <= rsp_set;
         if (rsp_set) begin
            rsp_fault_q <= rsp_flt_d;
            rsp_paddr_q <= rsp_pa_d;
         end
         if (st_q == W_IDLE) begin
            if (req_valid) begin
               va_q   <= req_vaddr;
               wr_q   <= req_write;
               drop_q <= 1'b0;
            end
         end else if (flush_pulse) begin
            drop_q <= 1'b1;
         end
         if (st_q == W_DIR_WAIT && mem_rsp_valid)
            pt_addr_q <= {mem_rsp_data[31:6], 6'b0}
                       + {{(32-IDX_W-2){1'b0}}, va_q[21:12], 2'b00};
      end
   end

   assign req_ready     = (st_q == W_IDLE);
   assign mem_req_valid = (st_q == W_DIR_REQ) || (st_q == W_PTE_REQ);
   assign mem_req_addr  = (st_q == W_DIR_REQ) ? {tbase[31:12], va_q[31:22], 2'b00}
                                              : pt_addr_q;
   assign rsp_valid     = rsp_valid_q;
   assign rsp_fault     = rsp_fault_q;
   assign rsp_paddr     = rsp_paddr_q;
   assign fill_en       = fill_ok && !drop_q && !flush_pulse;
   assign fill_vpn      = va_q[VA_W-1:OFF_W];
   assign fill_ppn      = pte_ppn(mem_rsp_data);
   assign fill_wr       = mem_rsp_data[2];
   assign fault_va      = (st_q == W_IDLE) ? req_vaddr : va_q;

   p_read_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
   p_hit_next_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && enable && hit) |=> rsp_valid);
   p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !enable) |=>
      (rsp_valid && !rsp_fault && rsp_paddr == {8'h00, $past(req_vaddr)}));
   p_fault_zero_pa_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
   p_no_read_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req_valid);
endmodule

// File: rtl/iova_walker.sv
module iova_walker
   import iovw_pkg::*;
#(
   parameter int CACHE_ENTRIES = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        irq,
   input  logic        req_valid,
   output logic        req_ready,
   input  logic [31:0] req_vaddr,
   input  logic        req_write,
   output logic        rsp_valid,
   output logic [39:0] rsp_paddr,
   output logic        rsp_fault,
   output logic        mem_req_valid,
   input  logic        mem_req_ready,
   output logic [31:0] mem_req_addr,
   input  logic        mem_rsp_valid,
   input  logic [31:0] mem_rsp_data
);
   generate
      if (CACHE_ENTRIES < 1 || CACHE_ENTRIES > 16) begin : g_bad_entries
         $error("iova_walker: CACHE_ENTRIES must be 1..16");
      end
   endgenerate

   logic             enable, flush_pulse;
   logic [31:0]      tbase;
   logic             hit, hit_wr, fill_en, fill_wr;
   logic [PPN_W-1:0] hit_ppn, fill_ppn;
   logic [VPN_W-1:0] fill_vpn;
   logic             fault_set;
   logic [ST_W-1:0]  fault_code;
   logic [VA_W-1:0]  fault_va;

   iovw_csr u_csr (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
      .fault_set, .fault_code, .fault_va,
      .enable, .tbase, .flush_pulse, .irq
   );

   iovw_tlb #(.ENTRIES(CACHE_ENTRIES)) u_tlb (
      .clk, .rst_n, .flush(flush_pulse),
      .look_vpn(req_vaddr[VA_W-1:OFF_W]),
      .hit, .hit_ppn, .hit_wr,
      .fill_en, .fill_vpn, .fill_ppn, .fill_wr
   );

   iovw_walk u_walk (
      .clk, .rst_n, .enable, .tbase, .flush_pulse,
      .req_valid, .req_ready, .req_vaddr, .req_write,
      .rsp_valid, .rsp_paddr, .rsp_fault,
      .mem_req_valid, .mem_req_ready, .mem_req_addr,
      .mem_rsp_valid, .mem_rsp_data,
      .hit, .hit_ppn, .hit_wr,
      .fill_en, .fill_vpn, .fill_ppn, .fill_wr,
      .fault_set, .fault_code, .fault_va
   );
endmodule

// File: tb/tb_iova_walker.sv
`timescale 1ns/1ps
module tb_iova_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        rsp_valid;
   logic [39:0] rsp_paddr;
   logic        rsp_fault;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b1;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;

   iova_walker dut (.*);

   always #2 clk = ~clk;

   localparam logic [31:0] TB = 32'h0010_0000;
   int n_chk = 0;
   int n_fail = 0;
   int lat = 1;
   int rd_cnt = 0;
   logic [31:0] rd_addr [4];
   bit [31:0] mem_img [bit [31:0]];
   bit done = 0;

   function automatic logic [9:0] dsel(input int k);
      case (k)
         0: return 10'd0;
         1: return 10'd1;
         2: return 10'd512;
         default: return 10'd1023;
      endcase
   endfunction
   function automatic logic [31:0] ptb(input int k);
      return 32'h0020_0040 + 32'(k) * 32'h1000;
   endfunction
   function automatic logic [31:0] pte(input int k, input int t);
      logic [19:0] lo = 20'h40000 + 20'(k * 16 + t);
      logic [7:0]  hi = 8'(k * 8 + t + 1);
      return {lo, hi, 1'b0, 1'(t % 2), 1'b0, 1'(t != 7)};
   endfunction
   function automatic logic [31:0] va_of(input int k, input int t, input logic [11:0] off);
      return {dsel(k), 10'(t), off};
   endfunction
   function automatic logic [39:0] pa_of(input int k, input int t, input logic [11:0] off);
      logic [31:0] e = pte(k, t);
      return {e[11:4], e[31:12], off};
   endfunction

   // memory responder
   initial begin : resp
      logic [31:0] a;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (mem_req_valid) begin
            a = mem_req_addr;
            if (rd_cnt < 4) rd_addr[rd_cnt] = a;
            rd_cnt++;
            repeat (lat) @(negedge clk);
            mem_rsp_data  = mem_img.exists(a) ? mem_img[a] : 32'h0;
            mem_rsp_valid = 1'b1;
         end
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic xlate(input logic [31:0] va, input logic wr,
                        output logic [39:0] pa, output logic flt,
                        output int cyc, output int nrd);
      @(negedge clk);
      rd_cnt = 0;
      req_valid = 1'b1; req_vaddr = va; req_write = wr;
      chk("R4 ready before request", 64'(req_ready), 64'd1);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 1;
      while (!rsp_valid && cyc < 300) begin
         @(negedge clk);
         cyc++;
      end
      pa = rsp_paddr; flt = rsp_fault; nrd = rd_cnt;
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin : main
      logic [39:0] pa;
      logic        flt;
      int          cyc, nrd;
      logic [31:0] rv;
      logic [31:0] va;

      for (int k = 0; k < 4; k++) begin
         mem_img[TB + {20'b0, dsel(k), 2'b00}] = ptb(k) | 32'h1;
         for (int t = 0; t < 8; t++) mem_img[ptb(k) + 32'(4 * t)] = pte(k, t);
      end

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state, R10 register map
      reg_read(3'd0, rv); chk("R1 ctrl after reset", 64'(rv), 0);
      reg_read(3'd3, rv); chk("R1 status after reset", 64'(rv), 0);
      reg_read(3'd4, rv); chk("R1 fault addr after reset", 64'(rv), 0);
      chk("R1 irq after reset", 64'(irq), 0);

      // R2 bypass while disabled
      xlate(32'h1234_5678, 1'b0, pa, flt, cyc, nrd);
      chk("R2 bypass paddr", 64'(pa), 64'h00_1234_5678);
      chk("R2 bypass latency", 64'(cyc), 1);
      chk("R2 bypass no read", 64'(nrd), 0);
      xlate(32'hFEDC_BA98, 1'b1, pa, flt, cyc, nrd);
      chk("R2 bypass write paddr", 64'(pa), 64'h00_FEDC_BA98);
      chk("R2 bypass no fault", 64'(flt), 0);

      // R3 base register low bits, R10 enable
      reg_write(3'd1, TB | 32'h0ABC);
      reg_read(3'd1, rv); chk("R3 base readback", 64'(rv), 64'(TB));
      reg_write(3'd0, 32'h1);
      reg_read(3'd0, rv); chk("R10 enable readback", 64'(rv), 1);

      // sweep: R3 R4 R5 on misses, R6 on hits
      for (int k = 0; k < 4; k++) begin
         for (int t = 0; t < 7; t++) begin
            logic [11:0] off = 12'((k * 7 + t * 13) * 37);
            lat = 1 + ((k + t) % 3);
            va = va_of(k, t, off);
            xlate(va, 1'b0, pa, flt, cyc, nrd);
            if (k == 0 && t == 0) chk("R1 first access walks", 64'(nrd), 2);
            chk("R5 walk paddr", 64'(pa), 64'(pa_of(k, t, off)));
            chk("R5 walk no fault", 64'(flt), 0);
            chk("R4 walk reads", 64'(nrd), 2);
            chk("R5 walk latency", 64'(cyc), 64'(2 * lat + 3));
            chk("R3 directory address", 64'(rd_addr[0]), 64'(TB + {20'b0, dsel(k), 2'b00}));
            chk("R4 page address", 64'(rd_addr[1]), 64'(ptb(k) + 32'(4 * t)));
            xlate(va_of(k, t, ~off), 1'(t % 2), pa, flt, cyc, nrd);
            chk("R6 hit paddr", 64'(pa), 64'(pa_of(k, t, ~off)));
            chk("R6 hit latency", 64'(cyc), 1);
            chk("R6 hit no read", 64'(nrd), 0);
         end
      end

      // R6 replacement order
      lat = 1;
      reg_write(3'd2, 32'h10);
      reg_write(3'd2, 32'h0);
      for (int t = 0; t < 5; t++) begin
         xlate(va_of(0, t, 12'h010), 1'b0, pa, flt, cyc, nrd);
         chk("R6 fill walk", 64'(nrd), 2);
      end
      xlate(va_of(0, 1, 12'h020), 1'b0, pa, flt, cyc, nrd);
      chk("R6 second fill kept", 64'(nrd), 0);
      xlate(va_of(0, 4, 12'h020), 1'b0, pa, flt, cyc, nrd);
      chk("R6 newest fill kept", 64'(nrd), 0);
      xlate(va_of(0, 0, 12'h020), 1'b0, pa, flt, cyc, nrd);
      chk("R6 oldest replaced", 64'(nrd), 2);

      // R7 flush
      xlate(va_of(1, 2, 12'h100), 1'b0, pa, flt, cyc, nrd);
      xlate(va_of(1, 2, 12'h104), 1'b0, pa, flt, cyc, nrd);
      chk("R7 cached before flush", 64'(nrd), 0);
      reg_write(3'd2, 32'h10);
      reg_read(3'd2, rv); chk("R7 flush bit readback", 64'(rv), 64'h10);
      reg_write(3'd2, 32'h0);
      reg_read(3'd2, rv); chk("R7 flush bit cleared", 64'(rv), 0);
      xlate(va_of(1, 2, 12'h108), 1'b0, pa, flt, cyc, nrd);
      chk("R7 walk after flush", 64'(nrd), 2);
      chk("R7 paddr after flush", 64'(pa), 64'(pa_of(1, 2, 12'h108)));

      // R7 flush during walk: answer but no fill
      lat = 4;
      fork
         xlate(va_of(2, 3, 12'h0F0), 1'b0, pa, flt, cyc, nrd);
         begin
            repeat (3) @(negedge clk);
            reg_write(3'd2, 32'h10);
            reg_write(3'd2, 32'h0);
         end
      join
      chk("R7 in-flight answer", 64'(pa), 64'(pa_of(2, 3, 12'h0F0)));
      lat = 1;
      xlate(va_of(2, 3, 12'h0F4), 1'b0, pa, flt, cyc, nrd);
      chk("R7 in-flight walk not filled", 64'(nrd), 2);

      // R8 directory fault
      lat = 2;
      va = 32'h0140_2345;
      xlate(va, 1'b0, pa, flt, cyc, nrd);
      chk("R8 dir fault flag", 64'(flt), 1);
      chk("R8 dir fault paddr", 64'(pa), 0);
      chk("R8 dir fault reads", 64'(nrd), 1);
      chk("R8 dir fault latency", 64'(cyc), 64'(lat + 2));
      reg_read(3'd3, rv); chk("R8 dir status", 64'(rv), 1);
      reg_read(3'd4, rv); chk("R8 dir fault addr", 64'(rv), 64'(va));
      chk("R8 irq set", 64'(irq), 1);
      reg_write(3'd3, 32'h0);
      reg_read(3'd3, rv); chk("R9 status cleared", 64'(rv), 0);
      chk("R9 irq cleared", 64'(irq), 0);

      // R8 page fault
      va = va_of(0, 7, 12'h321);
      xlate(va, 1'b0, pa, flt, cyc, nrd);
      chk("R8 page fault flag", 64'(flt), 1);
      chk("R8 page fault latency", 64'(cyc), 64'(2 * lat + 3));
      reg_read(3'd3, rv); chk("R8 page status", 64'(rv), 2);

      // R8 write to read-only page via walk
      va = va_of(3, 2, 12'h044);
      xlate(va, 1'b1, pa, flt, cyc, nrd);
      chk("R8 read-only walk fault", 64'(flt), 1);
      chk("R8 read-only paddr", 64'(pa), 0);
      reg_read(3'd3, rv); chk("R8 status accumulates", 64'(rv), 6);
      reg_read(3'd4, rv); chk("R8 fault addr updated", 64'(rv), 64'(va));
      xlate(va, 1'b0, pa, flt, cyc, nrd);
      chk("R9 faulted walk not filled", 64'(nrd), 2);
      chk("R9 read after fault ok", 64'(flt), 0);

      // R8 write to read-only cached page
      reg_write(3'd3, 32'h0);
      va = va_of(3, 2, 12'h048);
      xlate(va, 1'b1, pa, flt, cyc, nrd);
      chk("R8 hit write fault", 64'(flt), 1);
      chk("R8 hit fault latency", 64'(cyc), 1);
      chk("R8 hit fault no read", 64'(nrd), 0);
      reg_read(3'd3, rv); chk("R8 hit fault status", 64'(rv), 4);
      reg_read(3'd4, rv); chk("R8 hit fault addr", 64'(rv), 64'(va));

      // R9 masked clear
      xlate(32'h0144_0000, 1'b0, pa, flt, cyc, nrd);
      reg_read(3'd3, rv); chk("R9 status before mask", 64'(rv), 5);
      reg_write(3'd3, 32'h3);
      reg_read(3'd3, rv); chk("R9 masked write", 64'(rv), 1);
      chk("R9 irq still set", 64'(irq), 1);
      reg_write(3'd3, 32'h0);
      chk("R9 irq low after clear", 64'(irq), 0);

      // R10 disable returns to bypass
      reg_write(3'd0, 32'h0);
      xlate(32'h0000_1ABC, 1'b0, pa, flt, cyc, nrd);
      chk("R10 disabled bypass", 64'(pa), 64'h00_0000_1ABC);
      chk("R10 disabled no read", 64'(nrd), 0);

      finish_up();
   end
endmodule